// File: doc/BRIEF.md
# Macro Write-Back and Method Send Stage

This stage closes out each instruction of a command-macro processor. It receives the ALU result together with the instruction word, decodes the three-bit assignment mode and the destination register index, and then does three things: it writes the register file, it updates a stored method address and stride, and it may pop one parameter from the argument FIFO. It also issues send transactions, each carrying a 12-bit method address and a 32-bit data word, to the method consumer.

The method address and its stride are packed into one word. The low 12 bits are the address and bits 17:12 are a 6-bit stride. After every send the stride is added to the address, so consecutive sends walk through the method space without extra instructions.

An instruction retires in a single cycle. It retires only when every resource its mode needs is available: a parameter pop, a send, or both. Until then the stage stalls and performs no partial pop or send. A start pulse loads register 1 with the first macro argument.

Top module: `macro_wb_unit`

## Requirements
- R1: After reset, the method address and the stride are both 0. With no instruction and no start pulse, the stage raises none of rf_we, snd_valid and prm_ready.
- R2: The assignment mode is taken from instruction bits 6:4 and the destination index from bits 10:8. The modes are: 0 fetch-only, 1 move, 2 move+set-address, 3 fetch+send-result, 4 move+send, 5 fetch+set-address, 6 move+set-address then send the fetched parameter, 7 move+set-address then send the stride field.
- R3: An instruction that retires with destination index 0 does not assert rf_we.
- R4: While start is high, the stage writes start_arg to register 1 and holds op_ready low.
- R5: Setting the address (modes 2, 5, 6 and 7) loads the address from result bits 11:0 and the stride from result bits 17:12.
- R6: Each completed send advances the method address by the current stride, modulo 4096. In modes 6 and 7 the send uses the newly set address and the newly set stride.
- R7: Mode 0 writes the fetched parameter to the destination and discards the result. Mode 1 writes the result to the destination.
- R8: Mode 3 writes the fetched parameter to the destination and sends the result. Mode 4 writes the result to the destination and sends it.
- R9: Mode 5 writes the fetched parameter to the destination and sets the address from the result.
- R10: Mode 6 writes the result to the destination, sets the address from the result, and sends the fetched parameter to that new address.
- R11: Mode 7 writes the result to the destination, sets the address from the result, and sends result bits 17:12 zero-extended to 32 bits.
- R12: An instruction retires only when its pop and its send can both complete. prm_ready is raised only if the send side can complete, and snd_valid is raised only if the parameter side can complete. Neither is raised for a mode that does not use it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Macro start pulse |
| start_arg | input | 32 | First macro argument, loaded into register 1 |
| op_valid | input | 1 | Instruction and result present |
| op_ready | output | 1 | Instruction retires this cycle |
| op_word | input | 32 | Instruction word (mode in 6:4, destination in 10:8) |
| op_result | input | 32 | ALU result |
| prm_valid | input | 1 | Parameter FIFO has data |
| prm_ready | output | 1 | Pop parameter |
| prm_data | input | 32 | Parameter FIFO head |
| snd_valid | output | 1 | Send transaction present |
| snd_ready | input | 1 | Consumer accepts send |
| snd_addr | output | 12 | Send method address |
| snd_data | output | 32 | Send data |
| rf_we | output | 1 | Register file write enable |
| rf_idx | output | 3 | Register file write index |
| rf_data | output | 32 | Register file write data |

## Verification
The assertions assume that start and op_valid never rely on each other. They also assume that the FIFO and send handshakes are judged within the same cycle, because the stage is purely combinational between its valid and ready signals. The stimulus holds op_valid and start mutually exclusive, except for one directed check of start priority. It sweeps every mode against every destination index and every combination of parameter-valid and send-ready. Address sequences are checked against a model of address and stride kept in the bench, including a wrap past 4095.

// File: rtl/macro_wb_unit.sv
module macro_wb_unit #(
  parameter int DW = 32,
  parameter int AW = 12,
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] start_arg,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [DW-1:0] op_word,
  input  logic [DW-1:0] op_result,
  input  logic          prm_valid,
  output logic          prm_ready,
  input  logic [DW-1:0] prm_data,
  output logic          snd_valid,
  input  logic          snd_ready,
  output logic [AW-1:0] snd_addr,
  output logic [DW-1:0] snd_data,
  output logic          rf_we,
  output logic [2:0]    rf_idx,
  output logic [DW-1:0] rf_data
);
  localparam logic [2:0] M_FETCH = 3'd0, M_MOVE = 3'd1, M_MOVSA = 3'd2, M_FSEND = 3'd3,
                         M_MSEND = 3'd4, M_FSA = 3'd5, M_SAFS = 3'd6, M_SAHI = 3'd7;

  logic [AW-1:0] addr_q;
  logic [SW-1:0] stride_q;

  wire [2:0] mode = op_word[6:4];
  wire [2:0] dst  = op_word[10:8];

  logic need_fetch, need_send, set_addr, dst_gets_prm;
  always_comb begin
    need_fetch   = mode inside {M_FETCH, M_FSEND, M_FSA, M_SAFS};
    need_send    = mode inside {M_FSEND, M_MSEND, M_SAFS, M_SAHI};
    set_addr     = mode inside {M_MOVSA, M_FSA, M_SAFS, M_SAHI};
    dst_gets_prm = mode inside {M_FETCH, M_FSEND, M_FSA};
  end

  wire           active   = op_valid && !start;
  wire           prm_ok   = !need_fetch || prm_valid;
  wire           snd_ok   = !need_send || snd_ready;
  wire           fire     = active && prm_ok && snd_ok;
  wire [AW-1:0]  addr_eff = set_addr ? op_result[AW-1:0] : addr_q;
  wire [SW-1:0]  strd_eff = set_addr ? op_result[AW+SW-1:AW] : stride_q;

  assign op_ready  = fire;
  assign prm_ready = active && need_fetch && snd_ok;
  assign snd_valid = active && need_send && prm_ok;
  assign snd_addr  = addr_eff;

  always_comb begin
    case (mode)
      M_SAFS:  snd_data = prm_data;
      M_SAHI:  snd_data = {{(DW-SW){1'b0}}, op_result[AW+SW-1:AW]};
      default: snd_data = op_result;
    endcase
  end

  assign rf_we   = start || (fire && dst != 3'd0);
  assign rf_idx  = start ? 3'd1 : dst;
  assign rf_data = start ? start_arg : (dst_gets_prm ? prm_data : op_result);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      stride_q <= '0;
    end else if (fire) begin
      addr_q   <= need_send ? addr_eff + AW'(strd_eff) : addr_eff;
      stride_q <= strd_eff;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !start) |-> (!rf_we && !snd_valid && !prm_ready)); // R1
  AST_START_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (rf_we && rf_idx == 3'd1 && rf_data == start_arg && !op_ready)); // R4
  AST_POP_ONLY_ON_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (prm_valid && prm_ready) |-> (op_valid && op_ready)); // R12
  AST_SEND_ONLY_ON_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_valid && snd_ready) |-> (op_valid && op_ready)); // R12
  AST_SEND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_valid && snd_ready && (mode == M_FSEND || mode == M_MSEND))
    |=> (addr_q == $past(snd_addr) + AW'($past(stride_q)) && $stable(stride_q))); // R6
  AST_SET_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && (mode == M_MOVSA || mode == M_FSA))
    |=> (addr_q == $past(op_result[AW-1:0]) && stride_q == $past(op_result[AW+SW-1:AW]))); // R5
  AST_DST0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_word[10:8] == 3'd0) |-> !rf_we); // R3
endmodule

// File: tb/sim_macro_wb_unit.sv
module sim_macro_wb_unit;
  localparam int PER = 10;
  logic clk = 0, rst_n = 0, start = 0, op_valid = 0, prm_valid = 0, snd_ready = 0;
  logic [31:0] start_arg = 0, op_word = 0, op_result = 0, prm_data = 0;
  logic op_ready, prm_ready, snd_valid, rf_we;
  logic [11:0] snd_addr;
  logic [31:0] snd_data, rf_data;
  logic [2:0] rf_idx;
  int n_chk = 0, n_bad = 0;
  logic [11:0] m_addr = 0;
  logic [5:0]  m_str = 0;

  always #(PER/2) clk = ~clk;

  macro_wb_unit u0 (.clk(clk), .rst_n(rst_n), .start(start), .start_arg(start_arg),
    .op_valid(op_valid), .op_ready(op_ready), .op_word(op_word), .op_result(op_result),
    .prm_valid(prm_valid), .prm_ready(prm_ready), .prm_data(prm_data),
    .snd_valid(snd_valid), .snd_ready(snd_ready), .snd_addr(snd_addr), .snd_data(snd_data),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string mtag(input int m);
    case (m)
      0, 1: return "R7 mode data";
      2:    return "R5 mode data";
      3, 4: return "R8 mode data";
      5:    return "R9 mode data";
      6:    return "R10 mode data";
      default: return "R11 mode data";
    endcase
  endfunction

  task automatic step(input int mode, input int dst, input logic [31:0] res,
                      input logic pv, input logic [31:0] pd, input logic sr);
    logic nf, ns, sa, fire;
    logic [11:0] na;
    logic [5:0] ni;
    logic [31:0] ed;
    @(negedge clk);
    op_valid = 1; op_word = 32'(mode) << 4 | 32'(dst) << 8 | 32'h0000_f00f;
    op_result = res; prm_valid = pv; prm_data = pd; snd_ready = sr;
    #1;
    nf = mode inside {0, 3, 5, 6};
    ns = mode inside {3, 4, 6, 7};
    sa = mode inside {2, 5, 6, 7};
    fire = (!nf || pv) && (!ns || sr);
    na = sa ? res[11:0] : m_addr;
    ni = sa ? res[17:12] : m_str;
    chk("R12 op_ready", 32'(op_ready), 32'(fire));
    chk("R12 prm_ready", 32'(prm_ready), 32'(nf && (!ns || sr)));
    chk("R12 snd_valid", 32'(snd_valid), 32'(ns && (!nf || pv)));
    chk("R3 rf_we", 32'(rf_we), 32'(fire && dst != 0));
    if (fire && dst != 0) begin
      chk("R2 rf_idx", 32'(rf_idx), 32'(dst));
      chk(mtag(mode), rf_data, (mode inside {0, 3, 5}) ? pd : res);
    end
    if (ns && fire) begin
      ed = (mode == 6) ? pd : (mode == 7) ? 32'(res[17:12]) : res;
      chk("R6 snd_addr", 32'(snd_addr), 32'(na));
      chk(mtag(mode), snd_data, ed);
    end
    @(posedge clk);
    if (fire) begin
      m_addr = ns ? na + 12'(ni) : na;
      m_str = ni;
    end
  endtask

  initial begin
    #(PER * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1 idle rf_we", 32'(rf_we), 0);
    chk("R1 idle snd_valid", 32'(snd_valid), 0);
    chk("R1 idle prm_ready", 32'(prm_ready), 0);
    step(4, 2, 32'h1234_5678, 0, 0, 1);   // R1 first send at address 0
    @(negedge clk);
    start = 1; start_arg = 32'hcafe_0001; op_valid = 1; op_word = 32'h0000_0310;
    #1;
    chk("R4 rf_we", 32'(rf_we), 1);
    chk("R4 rf_idx", 32'(rf_idx), 1);
    chk("R4 rf_data", rf_data, 32'hcafe_0001);
    chk("R4 op_ready", 32'(op_ready), 0);
    @(negedge clk); start = 0; op_valid = 0;
    // R6 wrap: address 0xFFE, stride 3
    step(2, 1, 32'h0000_3ffe, 0, 0, 0);
    step(4, 1, 32'h0000_0aaa, 0, 0, 1);
    step(4, 1, 32'h0000_0bbb, 0, 0, 1);
    for (int k = 0; k < 256; k++) begin
      step(k / 32, (k / 4) % 8, 32'h9e37_79b9 * 32'(k + 1), k[0], 32'h5bd1_e995 ^ 32'(k), k[1]);
    end
    @(negedge clk); op_valid = 0;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule